// File: doc/BRIEF.md
# Power-good delayed reset timer

This block drives an active-low reset line for a processor that sits on a regulated supply rail. Four comparator flags arrive from analog circuits that watch the rail. Two of them report the lower edge of the acceptable band and two report the upper edge. The block turns these flags into a window state with separate entry and exit thresholds on each side. It then filters that state so that power-good only changes after the window state has held steady for a programmable number of clock cycles.

Once power-good is established, a long delay counter runs from the system clock. The reset output is released only when the full delay has elapsed. A reset-request input holds the output low while it is high, and its release restarts the delay. Dropping the enable forces the output low and clears every counter. All six asynchronous inputs pass through a two-flop synchronizer before any logic uses them. The filter length and the delay length are parameters, with defaults of 64 µs and 216 ms at a 50 MHz clock.

Top module: `pg_reset_timer`

## Requirements
- R1: While `rst_n` is low, and after its release until power-good has been established and the delay has elapsed, `por_n` is 0.
- R2: The lower edge of the window is entered only when `vmon_lo_set` (rail at or above 92% of nominal) is 1. It is left only when `vmon_lo_hold` (rail at or above 88%) is 0. A rail between 88% and 92% therefore keeps the state it had before.
- R3: The upper edge of the window is left when `vmon_hi_set` (rail at or above 108%) is 1. It is re-entered only when `vmon_hi_hold` (rail at or above 105%) is 0. A rail between 105% and 108% keeps the state it had before.
- R4: Power-good changes only after the raw window state has differed from it for FILT_CYCLES consecutive cycles. A shorter excursion has no effect on `por_n`.
- R5: `por_n` rises exactly 3 + FILT_CYCLES + DELAY_CYCLES clock edges after the rail enters the window, counting from the first edge that samples the new flags.
- R6: Loss of power-good drives `por_n` to 0 on the next edge and clears the delay count, so the next release again takes the full delay.
- R7: While the synchronized `rst_req` is 1, `por_n` is 0 whatever the power-good state.
- R8: When `rst_req` falls with power-good true, `por_n` rises exactly 2 + DELAY_CYCLES edges later. When `rst_req` falls with the rail outside the window, `por_n` stays 0.
- R9: While `enable` is low, `por_n` is 0 and the filter and delay counters are cleared. After `enable` rises, the full filter and delay run again.
- R10: Every asynchronous input passes two flops before use, so a change on `rst_req` or `enable` does not affect `por_n` until the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the filter and delay counters |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Regulator enable; low forces the reset output low |
| rst_req | input | 1 | External reset request, active high (asynchronous) |
| vmon_lo_set | input | 1 | Rail at or above the lower entry threshold (92%) |
| vmon_lo_hold | input | 1 | Rail at or above the lower exit threshold (88%) |
| vmon_hi_set | input | 1 | Rail at or above the upper trip threshold (108%) |
| vmon_hi_hold | input | 1 | Rail at or above the upper recovery threshold (105%) |
| por_n | output | 1 | Active-low processor reset, 1 means released |

## Verification
The bench targets the hysteresis bands. It parks the rail between the exit and entry thresholds on each side and checks that the output keeps its earlier state. A design that used a single threshold per side would release or assert the reset there. It sends glitches one cycle shorter than the filter and checks that the output does not move. A filter that did not restart on each change would drop the output. It measures the release edge exactly after power-up, after a window exit, after a reset request and after re-enable, where an off-by-one counter or a counter that was not cleared shows up as an early or late release. Random rail levels, requests and enable drops are also checked cycle by cycle against a reference model built from the requirements.

// File: rtl/pgrt_pkg.sv
// Shared types for the power-good delayed reset timer.
// Assumes every field of mon_t is an asynchronous single-bit input.
package pgrt_pkg;

    // Asynchronous inputs bundled for the synchronizer bank
    typedef struct packed {
        logic en;       // regulator enable
        logic req;      // external reset request
        logic lo_set;   // rail >= lower entry threshold
        logic lo_hold;  // rail >= lower exit threshold
        logic hi_set;   // rail >= upper trip threshold
        logic hi_hold;  // rail >= upper recovery threshold
    } mon_t;

    localparam int MON_W = $bits(mon_t);

endpackage

// File: rtl/pgrt_sync.sv
// Multi-bit bank of independent flop-chain synchronizers.
// Each bit is treated as unrelated to the others; no bus coherence is assumed.
module pgrt_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the asynchronous bit through STAGES flops
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[i]};
        end

        assign q[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/pgrt_window.sv
// Window detector with separate entry and exit thresholds on each side.
// Assumes the inputs are synchronized and that the set flag implies the hold flag
// on the lower side and the hold flag on the upper side implies nothing extra.
module pgrt_window (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_set,
    input  logic lo_hold,
    input  logic hi_set,
    input  logic hi_hold,
    output logic in_win
);

    logic lo_ok;    // rail counted as above the lower edge
    logic hi_trip;  // rail counted as above the upper edge

    // Lower edge: enter on the higher threshold, leave on the lower one
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_ok <= 1'b0;
        else if (lo_ok) lo_ok <= lo_hold;
        else            lo_ok <= lo_set;
    end

    // Upper edge: trip on the higher threshold, recover below the lower one
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_trip <= 1'b0;
        else if (hi_trip) hi_trip <= hi_hold;
        else              hi_trip <= hi_set;
    end

    assign in_win = lo_ok & ~hi_trip;

endmodule

// File: rtl/pgrt_filter.sv
// Stability filter: the output follows the input only after the input has
// differed from it for CYCLES consecutive clocks. Any return restarts the count.
// Assumes CYCLES >= 2.
module pgrt_filter #(
    parameter int CYCLES = 3200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic raw,
    output logic pg
);

    localparam int CW = $clog2(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    // Count cycles of disagreement; commit the new level at the last one
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            pg  <= 1'b0;
        end else if (raw != pg) begin
            if (cnt == LAST) begin
                cnt <= '0;
                pg  <= raw;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/pgrt_delay.sv
// Long release delay: counts while the block is enabled, power is good and no
// reset is requested; releases the output after CYCLES clocks and holds it.
// Assumes CYCLES >= 2.
module pgrt_delay #(
    parameter int CYCLES = 10_800_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req,
    input  logic pg,
    output logic rel
);

    localparam int CW = $clog2(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          hold;

    assign hold = !en || req || !pg;

    // Clear on any hold condition, otherwise count up to the release point
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt <= '0;
            rel <= 1'b0;
        end else if (cnt == LAST) begin
            rel <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pg_reset_timer.sv
// Power-good delayed reset timer: synchronizes the rail comparator flags, the
// enable and the reset request, builds a hysteretic window state, filters it
// into power-good and releases the active-low reset after a long delay.
// Assumes a free-running clk; delays are given in clk cycles.
module pg_reset_timer #(
    parameter int FILT_CYCLES  = 3200,
    parameter int DELAY_CYCLES = 10_800_000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rst_req,
    input  logic vmon_lo_set,
    input  logic vmon_lo_hold,
    input  logic vmon_hi_set,
    input  logic vmon_hi_hold,
    output logic por_n
);

    import pgrt_pkg::*;

    mon_t mon_raw;
    mon_t mon_s;
    logic en_s;
    logic req_s;
    logic in_win;
    logic pg_q;
    logic rel;

    assign mon_raw = '{en: enable, req: rst_req,
                       lo_set: vmon_lo_set, lo_hold: vmon_lo_hold,
                       hi_set: vmon_hi_set, hi_hold: vmon_hi_hold};

    pgrt_sync #(.WIDTH(MON_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (mon_raw),
        .q     (mon_s)
    );

    assign en_s  = mon_s.en;
    assign req_s = mon_s.req;

    pgrt_window u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_set  (mon_s.lo_set),
        .lo_hold (mon_s.lo_hold),
        .hi_set  (mon_s.hi_set),
        .hi_hold (mon_s.hi_hold),
        .in_win  (in_win)
    );

    pgrt_filter #(.CYCLES(FILT_CYCLES)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_s),
        .raw   (in_win),
        .pg    (pg_q)
    );

    pgrt_delay #(.CYCLES(DELAY_CYCLES)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_s),
        .req   (req_s),
        .pg    (pg_q),
        .rel   (rel)
    );

    assign por_n = rel;

endmodule

// File: rtl/pgrt_checker.sv
// Protocol checker for pg_reset_timer, attached by bind. Observes the
// synchronized controls, the window state, power-good and the output.
module pgrt_checker (
    input logic clk,
    input logic rst_n,
    input logic en_s,
    input logic req_s,
    input logic in_win,
    input logic pg_q,
    input logic por_n
);

    // R7: a pending reset request keeps the output asserted
    a_r7_req_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
        req_s |=> !por_n);

    // R9: a disabled block keeps the output asserted
    a_r9_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> !por_n);

    // R6: without power-good the output is asserted on the next edge
    a_r6_pg_loss_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_q |=> !por_n);

    // R5: release only ever follows a cycle with power-good
    a_r5_release_needs_pg: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_n) |-> $past(pg_q));

    // R4: power-good only moves toward the level the window state held
    a_r4_filter_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pg_q) && $past(en_s)) |-> ($past(in_win) == pg_q));

endmodule

bind pg_reset_timer pgrt_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_s   (en_s),
    .req_s  (req_s),
    .in_win (in_win),
    .pg_q   (pg_q),
    .por_n  (por_n)
);

// File: tb/tb_pg_reset_timer.sv
// Bench for pg_reset_timer: directed corner cases with exact edge counts,
// then seeded random rail levels compared against a requirement model.
module tb_pg_reset_timer;

    localparam int FILT  = 4;
    localparam int DELAY = 20;
    localparam int L     = 3 + FILT + DELAY;

    logic clk = 1'b0;
    logic rst_n, enable, rst_req;
    logic lo_set, lo_hold, hi_set, hi_hold;
    logic por_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    pg_reset_timer #(.FILT_CYCLES(FILT), .DELAY_CYCLES(DELAY)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rst_req(rst_req),
        .vmon_lo_set(lo_set), .vmon_lo_hold(lo_hold),
        .vmon_hi_set(hi_set), .vmon_hi_hold(hi_hold), .por_n(por_n));

    // Rail level in percent of nominal mapped to the four comparator flags
    task automatic set_rail(input int pct);
        lo_set  = (pct >= 92);
        lo_hold = (pct >= 88);
        hi_set  = (pct >= 108);
        hi_hold = (pct >= 105);
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic exp, input string req);
        n_tests++;
        if (por_n !== exp) begin
            n_fail++;
            $display("FAIL %s: por_n=%0b expected %0b at %0t", req, por_n, exp, $time);
        end
    endtask

    // Requirement model: two-flop inputs, hysteresis (R2, R3), filter (R4),
    // release delay with clears (R5..R9)
    logic [5:0] m_s1, m_s2;  // {en, req, lo_set, lo_hold, hi_set, hi_hold}
    bit m_lo, m_hi, m_raw, m_pg, m_out;
    int m_fc, m_dc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0;
            m_lo = 0; m_hi = 0; m_raw = 0; m_pg = 0; m_out = 0;
            m_fc = 0; m_dc = 0;
        end else begin
            if (!m_s2[5] || m_s2[4] || !m_pg) begin
                m_dc = 0; m_out = 0;
            end else if (m_dc == DELAY - 1) m_out = 1;
            else m_dc++;
            if (!m_s2[5]) begin
                m_fc = 0; m_pg = 0;
            end else if (m_raw != m_pg) begin
                if (m_fc == FILT - 1) begin m_pg = m_raw; m_fc = 0; end
                else m_fc++;
            end else m_fc = 0;
            m_lo  = m_lo ? m_s2[2] : m_s2[3];
            m_hi  = m_hi ? m_s2[0] : m_s2[1];
            m_raw = m_lo && !m_hi;
            m_s2  = m_s1;
            m_s1  = {enable, rst_req, lo_set, lo_hold, hi_set, hi_hold};
        end
    end

    function automatic int pick_level(input int k);
        case (k)
            0: return 80;   1: return 87;   2: return 89;  3: return 91;
            4: return 93;   5: return 100;  6: return 104; 7: return 106;
            8: return 107;  9: return 109;  default: return 115;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240613));
        rst_n = 0; enable = 0; rst_req = 0; set_rail(0);
        adv(3);
        chk(0, "R1 in reset");
        rst_n = 1;
        adv(2);
        chk(0, "R1 after reset");

        // R5: power-up release edge
        enable = 1; set_rail(100);
        adv(L - 1); chk(0, "R5 one edge early");
        adv(1);     chk(1, "R5 release edge");

        // R2: lower band hysteresis
        set_rail(90); adv(L + 5); chk(1, "R2 inside lower band keeps in");
        set_rail(87);
        adv(3 + FILT); chk(1, "R4 filter still holding");
        adv(1);        chk(0, "R6 drop one edge after pg loss");
        set_rail(90); adv(L + 5); chk(0, "R2 inside lower band keeps out");
        set_rail(93);
        adv(L - 1); chk(0, "R2 entry one edge early");
        adv(1);     chk(1, "R2 entry release");

        // R3: upper band hysteresis
        set_rail(106); adv(L + 5); chk(1, "R3 inside upper band keeps in");
        set_rail(109); adv(4 + FILT); chk(0, "R3 over-voltage trip");
        set_rail(106); adv(L + 5); chk(0, "R3 inside upper band keeps out");
        set_rail(104);
        adv(L - 1); chk(0, "R3 recovery one edge early");
        adv(1);     chk(1, "R3 recovery release");

        // R4: glitch one cycle shorter than the filter
        set_rail(80); adv(FILT - 1); set_rail(100);
        for (int i = 0; i < FILT + 6; i++) begin
            adv(1); chk(1, "R4 short glitch ignored");
        end

        // R6: full excursion clears the delay count
        set_rail(80); adv(4 + FILT); chk(0, "R6 full excursion drops");
        set_rail(100);
        adv(L - 1); chk(0, "R6 full delay again, early");
        adv(1);     chk(1, "R6 full delay again, release");

        // R7, R8, R10: reset request
        rst_req = 1;
        adv(2);  chk(1, "R10 two-flop latency");
        adv(1);  chk(0, "R7 request asserts output");
        adv(20); chk(0, "R7 request holds output");
        rst_req = 0;
        adv(1 + DELAY); chk(0, "R8 restart one edge early");
        adv(1);         chk(1, "R8 restart release");
        rst_req = 1; adv(5); set_rail(80); adv(FILT + 10);
        rst_req = 0; adv(L + 5); chk(0, "R8 release outside window stays low");
        set_rail(100); adv(L + 5); chk(1, "R8 back in window");

        // R9: enable
        enable = 0;
        adv(2);  chk(1, "R10 enable latency");
        adv(1);  chk(0, "R9 disable asserts output");
        adv(30); chk(0, "R9 disable holds output");
        enable = 1;
        adv(1 + FILT + DELAY); chk(0, "R9 re-enable one edge early");
        adv(1);                chk(1, "R9 re-enable release");

        // Random phase against the model
        for (int c = 0; c < 4000; c++) begin
            adv(1);
            chk(m_out, "R2 R3 R4 R6 R7 R9 random vs model");
            if ($urandom_range(0, 15) == 0) set_rail(pick_level($urandom_range(0, 10)));
            if ($urandom_range(0, 63) == 0) rst_req = ~rst_req;
            if ($urandom_range(0, 127) == 0) enable = ~enable;
            else if (!enable && $urandom_range(0, 7) == 0) enable = 1;
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule